// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shadowed Timing

This block generates four independent pulse-width modulated waveforms from a single clock. One clock cycle is one beat. Software programs each channel through a 32-bit word-addressed register bus. The bus has valid, write and address strobes, and read data is returned combinationally. Each channel has a period value and a beat count.

The waveform generator never reads the programmed values directly. It runs from private working copies. These copies are captured when the channel's run bit rises. While the channel runs, they are refreshed only after software writes the channel's refresh bit to 1 and then back to 0. Even then, the new values wait for the next period boundary, so a running waveform never changes in mid-period.

At the default polarity the beat count sets the number of low cycles at the start of each period, and the rest of the period is high. A beat count of zero therefore gives a steady high output. A polarity bit inverts the waveform. A stopped channel always drives low. A per-channel drive-enable bit is brought out to the pad logic.

Top module: `quad_pwm_shadow`

## Requirements
- R1: After reset every register reads zero except the idle-status register, which reads 0xF. All waveform outputs and drive enables are 0.
- R2: Register offsets are as follows. Beat count of channel n is at 8n. Period of channel n is at 8n+4. Polarity is at 0x40, run at 0x44, idle status at 0x48, refresh at 0x4C and drive enable at 0xD0. In the per-channel registers, bit n belongs to channel n. Beat and period fields are 30 bits wide (bits 31:30 read 0). Unmapped offsets read zero.
- R3: When a channel's run bit changes from 0 to 1, its period and beat registers are copied into the working copies at the next clock edge. At that same edge the channel starts at beat 0 of a fresh period.
- R4: At polarity 0, within each period of P working cycles, the output is low for the first B cycles (B = working beat count) and high for the remaining P−B cycles. B=0 gives a constant high. B≥P gives a constant low.
- R5: With a channel's polarity bit at 1, its running output is the inverse of the R4 waveform. The polarity bit takes effect immediately.
- R6: A channel whose run bit is 0 drives its output low, whatever its polarity. The stop takes effect one cycle after the write.
- R7: While a channel runs, writes to its period and beat registers do not change the waveform. After its refresh bit is written 1 and then 0, the registers are copied at the next period boundary, and the new waveform starts at beat 0.
- R8: A period register value of 0 or 1 is used as 2 in the working copy. The register itself still reads back as written.
- R9: Idle-status bit n reads 1 while channel n is stopped and 0 while it runs. Writes to the idle-status register are ignored.
- R10: The drive-enable outputs equal the drive-enable register bits, starting at the clock edge that writes them.
- R11: The channels are independent: starting, stopping or refreshing one channel does not change another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| pwm_out | output | 4 | Waveform per channel |
| pwm_oe | output | 4 | Drive enable per channel |

## Verification
A register write lands at the rising edge that samples it. Read data is valid combinationally in the same cycle, so the bench samples it 1 ns after driving. A run-bit rise reaches the working copies one edge after the write, so the first waveform cycle is visible two edges after the write. A refresh sequence changes the waveform only at the first period wrap that follows the falling refresh write. The bench's behavioural model advances on every rising edge with exactly these delays. The bench compares the model to the outputs at every falling edge, and then adds directed high-cycle counts taken over whole periods.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int unsigned OFF_POLARITY = 32'h40;
  localparam int unsigned OFF_RUN      = 32'h44;
  localparam int unsigned OFF_IDLE     = 32'h48;
  localparam int unsigned OFF_REFRESH  = 32'h4C;
  localparam int unsigned OFF_DRIVE    = 32'hD0;
  localparam int unsigned CH_STRIDE    = 8;
  localparam int unsigned MIN_PERIOD   = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BEAT, SEL_PERIOD, SEL_POL, SEL_RUN, SEL_IDLE, SEL_REFRESH, SEL_DRIVE
  } reg_sel_e;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import quad_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_CH-1:0]       idle_vec,
  output logic [NUM_CH*CNT_W-1:0] beat_flat,
  output logic [NUM_CH*CNT_W-1:0] period_flat,
  output logic [NUM_CH-1:0]       pol_q,
  output logic [NUM_CH-1:0]       run_q,
  output logic [NUM_CH-1:0]       refresh_q,
  output logic [NUM_CH-1:0]       drive_q
);
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_SPAN  = NUM_CH * CH_STRIDE;

  logic [CNT_W-1:0] beat_q   [NUM_CH];
  logic [CNT_W-1:0] period_q [NUM_CH];
  reg_sel_e         sel;
  logic [CH_IDX_W-1:0] ch_idx;
  logic             wr_en;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00)                  return SEL_NONE;
    if (int'(a) < CH_SPAN)                return a[2] ? SEL_PERIOD : SEL_BEAT;
    if (a == ADDR_W'(OFF_POLARITY))       return SEL_POL;
    if (a == ADDR_W'(OFF_RUN))            return SEL_RUN;
    if (a == ADDR_W'(OFF_IDLE))           return SEL_IDLE;
    if (a == ADDR_W'(OFF_REFRESH))        return SEL_REFRESH;
    if (a == ADDR_W'(OFF_DRIVE))          return SEL_DRIVE;
    return SEL_NONE;
  endfunction

  assign sel    = decode(bus_addr);
  assign ch_idx = bus_addr[3 +: CH_IDX_W];
  assign wr_en  = bus_valid & bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q     <= '0;
      run_q     <= '0;
      refresh_q <= '0;
      drive_q   <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        beat_q[i]   <= '0;
        period_q[i] <= '0;
      end
    end else if (wr_en) begin
      unique case (sel)
        SEL_BEAT:    beat_q[ch_idx]   <= bus_wdata[CNT_W-1:0];
        SEL_PERIOD:  period_q[ch_idx] <= bus_wdata[CNT_W-1:0];
        SEL_POL:     pol_q     <= bus_wdata[NUM_CH-1:0];
        SEL_RUN:     run_q     <= bus_wdata[NUM_CH-1:0];
        SEL_REFRESH: refresh_q <= bus_wdata[NUM_CH-1:0];
        SEL_DRIVE:   drive_q   <= bus_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      unique case (sel)
        SEL_BEAT:    bus_rdata = DATA_W'(beat_q[ch_idx]);
        SEL_PERIOD:  bus_rdata = DATA_W'(period_q[ch_idx]);
        SEL_POL:     bus_rdata = DATA_W'(pol_q);
        SEL_RUN:     bus_rdata = DATA_W'(run_q);
        SEL_IDLE:    bus_rdata = DATA_W'(idle_vec);
        SEL_REFRESH: bus_rdata = DATA_W'(refresh_q);
        SEL_DRIVE:   bus_rdata = DATA_W'(drive_q);
        default:     bus_rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign beat_flat[g*CNT_W +: CNT_W]   = beat_q[g];
    assign period_flat[g*CNT_W +: CNT_W] = period_q[g];
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import quad_pwm_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_bit,
  input  logic             refresh_bit,
  input  logic             pol_bit,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_beat,
  output logic             wave,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] work_period,
  output logic             load_evt,
  output logic             run_rise
);
  logic             run_d, refresh_d, pending;
  logic [CNT_W-1:0] work_beat;
  logic             refresh_fall, at_wrap;

  function automatic logic [CNT_W-1:0] clamp_period(input logic [CNT_W-1:0] p);
    return (p < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : p;
  endfunction

  function automatic logic level_of(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] b,
                                    input logic             inv);
    return (c >= b) ^ inv;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic             wrap);
    return wrap ? '0 : c + CNT_W'(1);
  endfunction

  assign running      = run_d;
  assign run_rise     = run_bit & ~run_d;
  assign refresh_fall = refresh_d & ~refresh_bit;
  assign at_wrap      = run_d && (count == work_period - CNT_W'(1));
  assign load_evt     = run_rise | (at_wrap & pending);
  assign wave         = run_d & level_of(count, work_beat, pol_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d       <= 1'b0;
      refresh_d   <= 1'b0;
      pending     <= 1'b0;
      count       <= '0;
      work_period <= '0;
      work_beat   <= '0;
    end else begin
      run_d     <= run_bit;
      refresh_d <= refresh_bit;
      if (run_rise)          pending <= 1'b0;
      else if (refresh_fall) pending <= 1'b1;
      else if (load_evt)     pending <= 1'b0;
      if (load_evt) begin
        work_period <= clamp_period(cfg_period);
        work_beat   <= cfg_beat;
      end
      if (run_rise)   count <= '0;
      else if (run_d) count <= step(count, at_wrap);
      else            count <= '0;
    end
  end
endmodule

// File: rtl/quad_pwm_shadow.sv
module quad_pwm_shadow
  import quad_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [NUM_CH*CNT_W-1:0] beat_flat, period_flat;
  logic [NUM_CH*CNT_W-1:0] count_flat, work_period_flat;
  logic [NUM_CH-1:0]       pol_q, run_q, refresh_q, drive_q;
  logic [NUM_CH-1:0]       run_vec, load_vec, rise_vec;

  pwm_regbank #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_vec(~run_vec),
    .beat_flat(beat_flat), .period_flat(period_flat),
    .pol_q(pol_q), .run_q(run_q), .refresh_q(refresh_q), .drive_q(drive_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .run_bit(run_q[g]), .refresh_bit(refresh_q[g]), .pol_bit(pol_q[g]),
      .cfg_period(period_flat[g*CNT_W +: CNT_W]),
      .cfg_beat(beat_flat[g*CNT_W +: CNT_W]),
      .wave(pwm_out[g]), .running(run_vec[g]),
      .count(count_flat[g*CNT_W +: CNT_W]),
      .work_period(work_period_flat[g*CNT_W +: CNT_W]),
      .load_evt(load_vec[g]), .run_rise(rise_vec[g])
    );
  end

  assign pwm_oe = drive_q;
endmodule

// File: rtl/quad_pwm_props.sv
module quad_pwm_props
  import quad_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [NUM_CH-1:0]       pwm_out,
  input logic [NUM_CH-1:0]       pwm_oe,
  input logic [NUM_CH-1:0]       run_vec,
  input logic [NUM_CH-1:0]       load_vec,
  input logic [NUM_CH-1:0]       rise_vec,
  input logic [NUM_CH*CNT_W-1:0] count_flat,
  input logic [NUM_CH*CNT_W-1:0] work_period_flat
);
  assert_stopped_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~run_vec) == '0);

  assert_drive_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(OFF_DRIVE))
    |=> pwm_oe == $past(bus_wdata[NUM_CH-1:0]));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    assert_start_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_vec[g] |=> (run_vec[g] && count_flat[g*CNT_W +: CNT_W] == '0));

    assert_count_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_vec[g] |-> count_flat[g*CNT_W +: CNT_W] < work_period_flat[g*CNT_W +: CNT_W]);

    assert_copy_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_vec[g] |=> $stable(work_period_flat[g*CNT_W +: CNT_W]));

    assert_min_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_vec[g] |-> work_period_flat[g*CNT_W +: CNT_W] >= CNT_W'(MIN_PERIOD));
  end
endmodule

bind quad_pwm_shadow quad_pwm_props #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
  .run_vec(run_vec), .load_vec(load_vec), .rise_vec(rise_vec),
  .count_flat(count_flat), .work_period_flat(work_period_flat)
);

// File: tb/quad_pwm_shadow_test.sv
module quad_pwm_shadow_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;

  int tests = 0, fails = 0;
  bit model_on = 1'b0;

  // behavioural reference state
  int m_beat[4], m_per[4], m_cnt[4], m_wp[4], m_wb[4];
  bit m_pol[4], m_run[4], m_rf[4], m_oe[4], m_act[4], m_rfd[4], m_pend[4];

  quad_pwm_shadow uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        bit rise, fall, wrap, ld;
        rise = m_run[i] && !m_act[i];
        fall = m_rfd[i] && !m_rf[i];
        wrap = m_act[i] && (m_cnt[i] == m_wp[i] - 1);
        ld   = rise || (wrap && m_pend[i]);
        if (rise) m_pend[i] = 0;
        else if (fall) m_pend[i] = 1;
        else if (ld) m_pend[i] = 0;
        if (rise || !m_act[i] || wrap) m_cnt[i] = 0;
        else m_cnt[i] = m_cnt[i] + 1;
        if (ld) begin
          m_wp[i] = (m_per[i] < 2) ? 2 : m_per[i];
          m_wb[i] = m_beat[i];
        end
        m_act[i] = m_run[i];
        m_rfd[i] = m_rf[i];
      end
      if (bus_valid && bus_write) begin
        int a;
        a = int'(bus_addr);
        if (a < 32 && a % 4 == 0) begin
          if (a % 8 == 0) m_beat[a / 8] = int'(bus_wdata & 32'h3FFF_FFFF);
          else m_per[a / 8] = int'(bus_wdata & 32'h3FFF_FFFF);
        end
        for (int i = 0; i < 4; i++) begin
          if (a == 'h40) m_pol[i] = bus_wdata[i];
          if (a == 'h44) m_run[i] = bus_wdata[i];
          if (a == 'h4C) m_rf[i]  = bus_wdata[i];
          if (a == 'hD0) m_oe[i]  = bus_wdata[i];
        end
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      for (int i = 0; i < 4; i++) begin
        bit e;
        e = m_act[i] ? ((m_cnt[i] >= m_wb[i]) ^ m_pol[i]) : 1'b0;
        check($sformatf("R3/R4/R5/R7/R11 model ch%0d", i), pwm_out[i], e);
        check("R10 model drive", pwm_oe[i], m_oe[i]);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 8'(a);
    #1 check(req, bus_rdata, exp);
    bus_valid = 0;
  endtask

  task automatic high_count(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    // R1 reset state
    check("R1 out", pwm_out, 0);
    check("R1 oe", pwm_oe, 0);
    rd_chk("R1 beat0", 'h00, 0);
    rd_chk("R1 period3", 'h1C, 0);
    rd_chk("R1 polarity", 'h40, 0);
    rd_chk("R1 run", 'h44, 0);
    rd_chk("R1 idle", 'h48, 32'hF);
    // R2 map, field width, unmapped
    wr('h0C, 32'hFFFF_FFFF);
    rd_chk("R2 period1 30-bit", 'h0C, 32'h3FFF_FFFF);
    rd_chk("R2 beat1 untouched", 'h08, 0);
    wr('h80, 32'h1234);
    rd_chk("R2 unmapped", 'h80, 0);
    rd_chk("R2 misaligned", 'h42, 0);
    // program channels
    wr('h00, 3); wr('h04, 8);
    wr('h08, 0); wr('h0C, 5);
    wr('h10, 1); wr('h14, 0);
    wr('h18, 4); wr('h1C, 6);
    wr('h40, 32'h8);
    rd_chk("R2 polarity", 'h40, 32'h8);
    rd_chk("R8 period2 raw readback", 'h14, 0);
    // R9 writes to idle ignored
    wr('h48, 0);
    rd_chk("R9 idle write ignored", 'h48, 32'hF);
    // R3 start all
    wr('h44, 32'hF);
    idle(2);
    rd_chk("R9 idle while running", 'h48, 0);
    idle(10);
    high_count(0, 8, h);  check("R4 ch0 high 5/8", h, 5);
    high_count(1, 20, h); check("R4 ch1 beat0 steady high", h, 20);
    high_count(2, 4, h);  check("R8 ch2 period clamped to 2", h, 2);
    high_count(3, 6, h);  check("R5 ch3 inverted high 4/6", h, 4);
    // R7 writes while running have no effect
    wr('h00, 1); wr('h04, 4);
    rd_chk("R7 beat0 reg new", 'h00, 1);
    idle(20);
    high_count(0, 8, h);  check("R7 ch0 unchanged before refresh", h, 5);
    wr('h4C, 1); wr('h4C, 0);
    idle(20);
    high_count(0, 4, h);  check("R7 ch0 after refresh 3/4", h, 3);
    high_count(1, 8, h);  check("R11 ch1 unaffected by refresh", h, 8);
    // R6 stop with polarity set
    wr('h40, 32'hF);
    wr('h44, 32'hC);
    idle(3);
    check("R6 stopped ch0/ch1 low", pwm_out[1:0], 0);
    high_count(0, 10, h); check("R6 ch0 low under polarity 1", h, 0);
    rd_chk("R9 idle after stop", 'h48, 32'h3);
    high_count(2, 4, h);  check("R11 ch2 runs on", h, 2);
    high_count(3, 6, h);  check("R11 ch3 runs on", h, 4);
    // R10 drive enable
    wr('hD0, 32'h5);
    idle(1);
    check("R10 drive enable", pwm_oe, 4'h5);
    rd_chk("R10 drive readback", 'hD0, 32'h5);
    // R3 restart ch0 picks up the current registers
    wr('h40, 32'h0);
    wr('h00, 2); wr('h04, 5);
    wr('h44, 32'hD);
    idle(4);
    high_count(0, 5, h);  check("R3 restart loads 3/5", h, 3);
    idle(5);
    model_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule